// File: doc/BRIEF.md
# Grouped Pin Interrupt Controller

This block turns external pin activity into sixteen latched interrupt requests. Each of the sixteen request channels watches one source, which is normally its own dedicated request pin. All pins first pass through a synchronizer. A per-channel sense mode then picks what counts as an event: low level, falling edge, rising edge or both edges. A detected event sets the channel's flag. The flag stays set until a per-channel clear input resets it. A channel drives its request output while its flag and its enable bit are both 1.

A mode bit switches on grouped operation. In grouped mode two channels also collect a bank of active-low key-sense and wake-up pins.

- Channel 6 takes key-sense pins 0 to 7.
- Channel 7 takes key-sense pins 8 to 15 and wake-up pins 0 to 7.

Every grouped pin has its own mask bit. The unmasked pins of a bank are ANDed, so any one of them going low pulls the shared source low. The grouped pins then use the sense mode, enable and flag of the channel they feed. Wake-up pins 8 to 15 never reach a request channel inside this block. A single-cycle write port loads the configuration words.

Top module: `gpic_top`

## Requirements
- R1: A channel's sense field selects its event: 00 = source low, 01 = high-to-low change, 10 = low-to-high change, 11 = any change. A pin change made between two rising clock edges shows on `irq_flag` after the third rising edge that follows it. The flag stays latched.
- R2: `irq_req[n]` is 1 exactly when `irq_flag[n]` and enable bit n are both 1. The enable bit has no effect on whether the flag sets.
- R3: A set flag holds until `flag_clr[n]` is high at a rising edge with no event detected on that channel in the same cycle. The flag is then 0 after that edge.
- R4: If an event and a clear meet at the same edge, the flag stays 1. A low-level channel whose source is still low therefore cannot be cleared.
- R5: Synchronous reset gives the following state:
  - all flags and requests 0;
  - all enables 0;
  - every key-sense and wake-up mask bit 1;
  - grouped mode off;
  - every sense field 00.
- R6: A write with `cfg_we` high stores `cfg_wdata` according to `cfg_addr`:
  - address 0: sense fields, with channel n in bits 2n+1:2n;
  - address 1: enables, with bit n for channel n;
  - address 2: key-sense masks, with bit i for key pin i;
  - address 3: wake-up masks, with bit j for wake pin j;
  - address 4: bit 0 = grouped mode.
  Writes to addresses 5 to 7 change nothing.
- R7: With grouped mode off, key-sense and wake-up pins have no effect. Every channel, 6 and 7 included, follows its own dedicated pin.
- R8: With grouped mode on, the sources of channels 6 and 7 are built as follows:
  - Channel 6 source is the AND of the unmasked key-sense pins 0 to 7. It is further ANDed with dedicated pin 6 only when key-sense mask bit 6 is 0.
  - Channel 7 source is the AND of the unmasked key-sense pins 8 to 15 and wake-up pins 0 to 7. It is ANDed with dedicated pin 7 only when all sixteen of those mask bits are 1.
- R9: Wake-up pins 8 to 15 and their mask bits never change any flag or request.
- R10: A masked grouped pin (mask bit 1) has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 16 | Dedicated request pins, one per channel |
| key_pin | input | 16 | Active-low key-sense pins |
| wake_pin | input | 16 | Active-low wake-up pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| flag_clr | input | 16 | Per-channel flag clear |
| irq_req | output | 16 | Request outputs (flag and enable) |
| irq_flag | output | 16 | Latched flag per channel |

## Verification
The assertions assume that every input is driven to a known value from the first clock edge. They also assume that grouped pins are only used while their shared channel senses low level or falling edges; the other modes are unsupported for grouped sources. The stimulus respects this: grouped sweeps run with channels 6 and 7 in falling-edge mode. Masks change only while every grouped pin is high, so no edge arises from reconfiguration alone. The full four-mode sweep is applied only to dedicated pins.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

    localparam int ADDR_W   = 3;
    localparam int KEY_W    = 16;
    localparam int WAKE_W   = 16;
    localparam int WAKE_GRP = 8;   // wake pins that join a shared channel
    localparam int GRP_SPLIT = 8;  // key pins below this feed the low channel
    localparam int CH_LO    = 6;
    localparam int CH_HI    = 7;

    localparam logic [ADDR_W-1:0] A_SENSE = 3'd0;
    localparam logic [ADDR_W-1:0] A_EN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_KMASK = 3'd2;
    localparam logic [ADDR_W-1:0] A_WMASK = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd4;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_FALL = 2'b01,
        SNS_RISE = 2'b10,
        SNS_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic [KEY_W-1:0]    kmask;
        logic [WAKE_GRP-1:0] wmask;
        logic                grp;
    } grp_cfg_t;

    function automatic logic sense_hit(input sense_e mode, input logic prev, input logic cur);
        logic hit;
        case (mode)
            SNS_LOW:  hit = ~cur;
            SNS_FALL: hit = prev & ~cur;
            SNS_RISE: hit = ~prev & cur;
            default:  hit = prev ^ cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpic_sync.sv
module gpic_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (STAGES <= 1) begin : g_one
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES*W-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[(STAGES-1)*W-1:0], din};
            end
            assign dout = sh[STAGES*W-1 -: W];
        end
    endgenerate
endmodule

// File: rtl/gpic_route.sv
module gpic_route
    import gpic_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  grp_cfg_t              cfg,
    input  logic [NUM_CH-1:0]     irq_s,
    input  logic [KEY_W-1:0]      key_s,
    input  logic [WAKE_GRP-1:0]   wake_s,
    output logic [NUM_CH-1:0]     src
);
    logic lo_bank, hi_bank, ded_hi_ok;

    always_comb begin
        // masked pins read as idle high; the bank is low if any live pin is low
        lo_bank   = &(key_s[GRP_SPLIT-1:0] | cfg.kmask[GRP_SPLIT-1:0]);
        hi_bank   = &({key_s[KEY_W-1:GRP_SPLIT], wake_s} |
                      {cfg.kmask[KEY_W-1:GRP_SPLIT], cfg.wmask});
        ded_hi_ok = &{cfg.kmask[KEY_W-1:GRP_SPLIT], cfg.wmask};
        src = irq_s;
        if (cfg.grp) begin
            src[CH_LO] = lo_bank & (irq_s[CH_LO] | cfg.kmask[CH_LO]);
            src[CH_HI] = hi_bank & (irq_s[CH_HI] | ~ded_hi_ok);
        end
    end
endmodule

// File: rtl/gpic_flags.sv
module gpic_flags
    import gpic_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     src,
    input  logic [2*NUM_CH-1:0]   sense,
    input  logic [NUM_CH-1:0]     clr,
    output logic [NUM_CH-1:0]     set_vec,
    output logic [NUM_CH-1:0]     flag
);
    logic [NUM_CH-1:0] prev_q, flag_q;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign set_vec[i] = sense_hit(sense_e'(sense[2*i +: 2]), prev_q[i], src[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '1;
            flag_q <= '0;
        end else begin
            prev_q <= src;
            flag_q <= set_vec | (flag_q & ~clr);
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/gpic_top.sv
module gpic_top
    import gpic_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CH-1:0]    irq_pin,
    input  logic [KEY_W-1:0]     key_pin,
    input  logic [WAKE_W-1:0]    wake_pin,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [NUM_CH-1:0]    flag_clr,
    output logic [NUM_CH-1:0]    irq_req,
    output logic [NUM_CH-1:0]    irq_flag
);
    localparam int SYN_W = NUM_CH + KEY_W + WAKE_GRP;

    logic [2*NUM_CH-1:0] sense_q;
    logic [NUM_CH-1:0]   en_q;
    grp_cfg_t            gcfg_q;

    logic [SYN_W-1:0]    syn_out;
    logic [NUM_CH-1:0]   irq_s, src, set_vec;
    logic [KEY_W-1:0]    key_s;
    logic [WAKE_GRP-1:0] wake_s;

    // upper wake-up pins are configured and consumed outside this block
    logic unused_wake_hi;
    assign unused_wake_hi = ^wake_pin[WAKE_W-1:WAKE_GRP];

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q      <= '0;
            en_q         <= '0;
            gcfg_q.kmask <= '1;
            gcfg_q.wmask <= '1;
            gcfg_q.grp   <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_SENSE: sense_q      <= cfg_wdata[2*NUM_CH-1:0];
                A_EN:    en_q         <= cfg_wdata[NUM_CH-1:0];
                A_KMASK: gcfg_q.kmask <= cfg_wdata[KEY_W-1:0];
                A_WMASK: gcfg_q.wmask <= cfg_wdata[WAKE_GRP-1:0];
                A_MODE:  gcfg_q.grp   <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    gpic_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({wake_pin[WAKE_GRP-1:0], key_pin, irq_pin}),
        .dout (syn_out)
    );

    assign irq_s  = syn_out[NUM_CH-1:0];
    assign key_s  = syn_out[NUM_CH +: KEY_W];
    assign wake_s = syn_out[NUM_CH+KEY_W +: WAKE_GRP];

    gpic_route #(.NUM_CH(NUM_CH)) u_route (
        .cfg    (gcfg_q),
        .irq_s  (irq_s),
        .key_s  (key_s),
        .wake_s (wake_s),
        .src    (src)
    );

    gpic_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .sense   (sense_q),
        .clr     (flag_clr),
        .set_vec (set_vec),
        .flag    (irq_flag)
    );

    assign irq_req = irq_flag & en_q;
endmodule

// File: rtl/gpic_chk.sv
module gpic_chk #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] flag,
    input logic [NUM_CH-1:0] set_vec,
    input logic [NUM_CH-1:0] clr,
    input logic [NUM_CH-1:0] src,
    input logic [NUM_CH-1:0] irq_s,
    input logic              grp
);
    // R1: a flag only rises after a detected event
    a_r1_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag & ~$past(flag) & ~$past(set_vec)) == '0));

    // R3: clear without a concurrent event empties the flag
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag & $past(clr & ~set_vec)) == '0));

    // R4: an event always leaves the flag set, clear or not
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_vec) & ~flag) == '0));

    // R7: ungrouped mode routes the dedicated pins straight through
    a_r7_passthrough: assert property (@(posedge clk) disable iff (rst)
        !grp |-> (src == irq_s));
endmodule

bind gpic_top gpic_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .flag    (irq_flag),
    .set_vec (set_vec),
    .clr     (flag_clr),
    .src     (src),
    .irq_s   (irq_s),
    .grp     (gcfg_q.grp)
);

// File: tb/gpic_top_tb.sv
`timescale 1ns/1ps
module gpic_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_pin  = '1;
    logic [15:0] key_pin  = '1;
    logic [15:0] wake_pin = '1;
    logic        cfg_we   = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] flag_clr = '0;
    logic [15:0] irq_req, irq_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpic_top u_dut (
        .clk(clk), .rst(rst), .irq_pin(irq_pin), .key_pin(key_pin),
        .wake_pin(wake_pin), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .flag_clr(flag_clr),
        .irq_req(irq_req), .irq_flag(irq_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clr_all();
        flag_clr = '1;
        tick(1);
        flag_clr = '0;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_set(input int m, input bit a, input bit b);
        case (m)
            0:       return !a || !b;
            1:       return a && !b;
            2:       return !a && b;
            default: return a != b;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] sense;
        logic [15:0] en;
        logic [15:0] expv;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R5: reset state
        chk("R5 flags", irq_flag, 16'h0);
        chk("R5 req", irq_req, 16'h0);

        // R5 masks reset to 1, R8 dedicated pin 7 passes with all masks set
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h5555_5555);
        wr(3'd1, 32'h0000_FFFF);
        key_pin = '0; wake_pin = '0;
        tick(4);
        chk("R5 masked group", irq_flag, 16'h0);
        key_pin = '1; wake_pin = '1;
        irq_pin[7] = 1'b0;
        tick(4);
        chk("R8 ch7 dedicated open", irq_flag, 16'h0080);
        irq_pin[7] = 1'b1;
        tick(4); clr_all(); tick(1);

        // R6: writes to unused addresses are dropped
        wr(3'd1, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        irq_pin[0] = 1'b0;
        tick(4);
        chk("R6 flag", irq_flag, 16'h0001);
        chk("R6 enable kept", irq_req, 16'h0);
        irq_pin[0] = 1'b1;
        tick(4); clr_all(); tick(1);

        // R7: ungrouped, group pins unmasked yet inert
        wr(3'd4, 32'd0);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        key_pin = '0; wake_pin = '0;
        tick(4);
        chk("R7 group inert", irq_flag, 16'h0);
        irq_pin[7] = 1'b0;
        tick(4);
        chk("R7 ch7 own pin", irq_flag, 16'h0080);
        irq_pin[7] = 1'b1; key_pin = '1; wake_pin = '1;
        tick(4); clr_all(); tick(1);
        chk("R7 idle", irq_flag, 16'h0);
        wr(3'd2, 32'hFFFF);
        wr(3'd3, 32'hFFFF);

        // R1 / R2: every channel, every mode, every transition
        for (int ch = 0; ch < 16; ch++) begin
            for (int m = 0; m < 4; m++) begin
                for (int t = 0; t < 4; t++) begin
                    bit a, b;
                    a = t[1]; b = t[0];
                    wr(3'd0, 32'h5555_5555);
                    irq_pin[ch] = a;
                    tick(4); clr_all(); tick(1);
                    sense = 32'h5555_5555;
                    sense[2*ch +: 2] = 2'(m);
                    en = ((ch + m + t) % 2 == 1) ? 16'hFFFF : 16'h0000;
                    wr(3'd1, {16'h0, en});
                    wr(3'd0, sense);
                    irq_pin[ch] = b;
                    tick(4);
                    expv = exp_set(m, a, b) ? (16'h1 << ch) : 16'h0;
                    chk("R1 flag", irq_flag, expv);
                    chk("R2 req", irq_req, expv & en);
                    wr(3'd0, 32'h5555_5555);
                    irq_pin[ch] = 1'b1;
                    tick(4); clr_all(); tick(1);
                end
            end
        end

        // R4: level channel cannot be cleared while low
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h5555_5515);  // channel 3 low level
        irq_pin[3] = 1'b0;
        tick(4);
        clr_all();
        chk("R4 level re-set", irq_flag, 16'h0008);
        irq_pin[3] = 1'b1;
        tick(4); clr_all(); tick(1);
        chk("R3 clear", irq_flag, 16'h0);

        // R4: set and clear at the same edge; R1 latency
        wr(3'd0, 32'h5555_5555);
        irq_pin[3] = 1'b0;
        tick(2);
        chk("R1 not yet", irq_flag, 16'h0);
        flag_clr[3] = 1'b1;
        tick(1);
        flag_clr[3] = 1'b0;
        chk("R4 set wins", irq_flag, 16'h0008);
        irq_pin[3] = 1'b1;
        tick(4);
        chk("R3 hold", irq_flag, 16'h0008);
        clr_all(); tick(1);
        chk("R3 clear edge", irq_flag, 16'h0);

        // R8 / R9 / R10: grouped sweep over every key and wake pin
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h5555_5555);
        wr(3'd1, 32'h0000_FFFF);
        for (int masked = 0; masked < 2; masked++) begin
            for (int p = 0; p < 32; p++) begin
                logic [15:0] km, wm;
                km = 16'hFFFF; wm = 16'hFFFF;
                if (masked == 0) begin
                    if (p < 16) km[p] = 1'b0;
                    else        wm[p-16] = 1'b0;
                end
                wr(3'd2, {16'h0, km});
                wr(3'd3, {16'h0, wm});
                if (p < 16) key_pin[p] = 1'b0;
                else        wake_pin[p-16] = 1'b0;
                tick(4);
                if (masked == 1)  expv = 16'h0;
                else if (p < 8)   expv = 16'h0040;
                else if (p < 24)  expv = 16'h0080;
                else              expv = 16'h0;
                if (masked == 1)       chk("R10 masked pin", irq_flag, expv);
                else if (p >= 24)      chk("R9 upper wake", irq_flag, expv);
                else                   chk("R8 group flag", irq_flag, expv);
                chk("R8 group req", irq_req, expv);
                key_pin = '1; wake_pin = '1;
                tick(4); clr_all(); tick(1);
            end
        end

        // R8: dedicated pin 7 blocked by an unmasked member
        wr(3'd2, 32'hFEFF);
        wr(3'd3, 32'hFFFF);
        irq_pin[7] = 1'b0;
        tick(4);
        chk("R8 ch7 blocked", irq_flag, 16'h0);
        irq_pin[7] = 1'b1;
        tick(4); clr_all(); tick(1);

        // R8: dedicated pin 6 needs key mask bit 6 at 0
        wr(3'd2, 32'hFFFF);
        irq_pin[6] = 1'b0;
        tick(4);
        chk("R8 ch6 pin ignored", irq_flag, 16'h0);
        irq_pin[6] = 1'b1;
        tick(4); clr_all(); tick(1);
        wr(3'd2, 32'hFFBF);
        irq_pin[6] = 1'b0;
        tick(4);
        chk("R8 ch6 pin used", irq_flag, 16'h0040);
        irq_pin[6] = 1'b1;
        tick(4); clr_all(); tick(1);

        finish_run();
    end
endmodule